// File: doc/BRIEF.md
# Per-Port Two-Priority Ingress/Egress Rate Limiter

This block polices the bandwidth of one switch port in both directions. Each frame is presented once, when it starts, with its byte length, a priority bit and a direction bit. One cycle later the block returns an accept/drop verdict. Limits are programmed as a count of 32 kbit/s steps, from 0 up to 3125 steps (100 Mbit/s). Each of the four direction/priority pairs has its own setting. A setting of zero means the pair is not limited.

Every pair keeps a token-bucket credit in bits. A fixed timebase tick adds `rate × STEP_CREDIT` bits to the credit. A frame that is admitted is charged `8 × length` bits. The credit may go negative, so one oversized frame can pass. A negative credit then refuses further frames until refills bring it back to zero or above.

For ingress, a policy bit chooses between two modes. In drop mode, frames are refused while the credit is negative. In flow-control mode, frames are still admitted and a pause request is raised for as long as an ingress credit is negative. Configuration is written through a small address/data register port. A rate write is staged and becomes active at the next tick.

Top module: `port_rate_policer`

## Requirements
- R1: After reset, `dec_valid` and `pause_req` are low, all four rates are 0 (unlimited), all credits are 0 and the ingress policy is drop.
- R2: A frame event sampled at a clock edge produces exactly one `dec_valid` pulse in the following cycle, carrying `dec_accept`. No pulse appears without an event.
- R3: A pair whose active rate is 0 accepts every frame and is not charged for it.
- R4: For a limited pair, a frame is accepted only if the credit is non-negative when the frame is seen. An accepted frame lowers the credit by 8 × `frm_len` bits, and the credit may go negative.
- R5: A tick occurs every TICK_CYCLES clock edges; the first one is the TICK_CYCLES-th edge after reset is released. At each tick the credit grows by `rate × STEP_CREDIT` and is limited to `MAX_FRAME_BYTES × 8 + rate × STEP_CREDIT`.
- R6: A rate write is applied at the next tick, and the refill at that tick already uses the new rate. Credits are not cleared by a write. Until that tick, admission (including the unlimited test) follows the old rate.
- R7: A written rate above 3125 steps is treated as 3125 steps.
- R8: `cfg_addr` selects the register: 0 is ingress low priority, 1 is ingress high, 2 is egress low, 3 is egress high. Address 4 bit 0 is the ingress policy (1 = flow control, 0 = drop) and takes effect from the next cycle. The four buckets are independent.
- R9: In ingress drop mode, a frame seen while its limited credit is negative is refused and not charged.
- R10: In ingress flow-control mode, ingress frames are always accepted and charged, and the credit stops at a floor of −(2^11−1)×8 bits. `pause_req` is high exactly while the policy is flow control and a limited ingress credit is negative.
- R11: An egress frame is refused while its limited credit is negative, whatever the policy. Egress credits never affect `pause_req`.
- R12: When a tick and a frame fall on the same edge, the verdict uses the credit from before the tick. The new credit is the capped refill minus the charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Frame start event |
| frm_egress | input | 1 | Direction: 1 = egress, 0 = ingress |
| frm_hi | input | 1 | Priority: 1 = high, 0 = low |
| frm_len | input | 11 | Frame length in bytes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register select (see R8) |
| cfg_wdata | input | 12 | Rate in 32 kbit/s steps, or policy in bit 0 |
| dec_valid | output | 1 | Verdict valid, one cycle after the event |
| dec_accept | output | 1 | 1 = admit frame, 0 = drop |
| pause_req | output | 1 | Ingress flow-control request |

## Verification
The two functions that can fall on one clock edge are the periodic refill and the charge of a frame. The bench tracks the tick phase from reset and places frames on the edge just before a tick, on the tick edge itself and on the edge just after. This shows that the verdict takes the pre-tick credit while the bucket absorbs both the refill and the charge. Rate writes placed next to a tick are judged in the same way, by the verdicts of the frames that follow and by the level of the pause request on every cycle.

// File: rtl/rl_pkg.sv
package rl_pkg;

    localparam int RATE_W    = 12;
    localparam int MAX_STEPS = 3125;
    localparam int LEN_W     = 11;
    localparam int CHG_W     = LEN_W + 3;
    localparam int NUM_BKT   = 4;
    localparam int ADDR_W    = 3;
    localparam int FLOOR_MAG = ((2 ** LEN_W) - 1) * 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_IN_LO  = 3'd0,
        REG_IN_HI  = 3'd1,
        REG_EG_LO  = 3'd2,
        REG_EG_HI  = 3'd3,
        REG_POLICY = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic             egress;
        logic             hi;
        logic [LEN_W-1:0] len;
    } frame_t;

    typedef struct packed {
        logic valid;
        logic accept;
    } verdict_t;

    function automatic logic [RATE_W-1:0] clamp_steps(input logic [RATE_W-1:0] r);
        return (r > RATE_W'(MAX_STEPS)) ? RATE_W'(MAX_STEPS) : r;
    endfunction

    function automatic logic [1:0] bucket_of(input frame_t f);
        return {f.egress, f.hi};
    endfunction

    function automatic logic [CHG_W-1:0] bits_of(input logic [LEN_W-1:0] len);
        return {len, 3'b000};
    endfunction

endpackage

// File: rtl/rl_tick_gen.sv
module rl_tick_gen #(
    parameter int TICK_CYCLES = 31250
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: ticks are isolated pulses (period of at least two cycles)
    a_r5_tick_isolated: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/rl_cfg_regs.sv
module rl_cfg_regs
    import rl_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            tick,
    input  logic                            cfg_we,
    input  logic [ADDR_W-1:0]               cfg_addr,
    input  logic [RATE_W-1:0]               cfg_wdata,
    output logic [NUM_BKT-1:0][RATE_W-1:0]  rate_new,
    output logic [NUM_BKT-1:0][RATE_W-1:0]  rate_act,
    output logic                            fc_mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fc_mode <= 1'b0;
        end else if (cfg_we && cfg_addr == REG_POLICY) begin
            fc_mode <= cfg_wdata[0];
        end
    end

    for (genvar b = 0; b < NUM_BKT; b++) begin : g_rate
        always_ff @(posedge clk) begin
            if (rst) begin
                rate_new[b] <= '0;
            end else if (cfg_we && cfg_addr == ADDR_W'(b)) begin
                rate_new[b] <= clamp_steps(cfg_wdata);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                rate_act[b] <= '0;
            end else if (tick) begin
                rate_act[b] <= rate_new[b];
            end
        end

        // R6: the active rate moves only on a tick
        a_r6_rate_at_tick: assert property (@(posedge clk) disable iff (rst)
            !tick |=> $stable(rate_act[b]));

        // R7: a written rate never exceeds the 100 Mbit/s step count
        a_r7_rate_clamped: assert property (@(posedge clk) disable iff (rst)
            $past(cfg_we) && $past(cfg_addr) == ADDR_W'(b) |->
                rate_new[b] <= RATE_W'(MAX_STEPS));
    end

endmodule

// File: rtl/rl_bucket.sv
module rl_bucket
    import rl_pkg::*;
#(
    parameter int CREDIT_W        = 17,
    parameter int STEP_CREDIT     = 8,
    parameter int MAX_FRAME_BYTES = 1916
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic [RATE_W-1:0]          rate_new,
    input  logic [RATE_W-1:0]          rate_act,
    input  logic                       charge,
    input  logic [CHG_W-1:0]           charge_bits,
    output logic signed [CREDIT_W-1:0] credit,
    output logic                       unlimited
);
    localparam int EXT_W = CREDIT_W + 2;
    localparam logic signed [EXT_W-1:0] FRAME_BITS = EXT_W'(MAX_FRAME_BYTES * 8);
    localparam logic signed [EXT_W-1:0] FLOOR      = EXT_W'(-FLOOR_MAG);
    localparam logic signed [EXT_W-1:0] STEP_K     = EXT_W'(STEP_CREDIT);

    function automatic logic signed [EXT_W-1:0] refill_of(input logic [RATE_W-1:0] r);
        return $signed({{(EXT_W - RATE_W){1'b0}}, r}) * STEP_K;
    endfunction

    logic signed [EXT_W-1:0] cur, refill, cap, sum, base, chg, nxt;

    assign unlimited = (rate_act == '0);
    assign cur       = EXT_W'(credit);
    assign refill    = refill_of(rate_new);
    assign cap       = FRAME_BITS + refill;
    assign chg       = $signed({{(EXT_W - CHG_W){1'b0}}, charge_bits});

    always_comb begin
        sum  = cur + refill;
        base = cur;
        if (tick) begin
            base = (sum > cap) ? cap : sum;
        end
        nxt = charge ? (base - chg) : base;
        if (nxt < FLOOR) begin
            nxt = FLOOR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            credit <= '0;
        end else begin
            credit <= CREDIT_W'(nxt);
        end
    end

    // R5: credit never exceeds one maximum frame plus one tick at the active rate
    a_r5_depth_cap: assert property (@(posedge clk) disable iff (rst)
        EXT_W'(credit) <= FRAME_BITS + refill_of(rate_act));

    // R10: credit never sinks below the floor
    a_r10_floor: assert property (@(posedge clk) disable iff (rst)
        EXT_W'(credit) >= FLOOR);

    // R4: a non-empty charge without a tick lowers the credit
    a_r4_charge_lowers: assert property (@(posedge clk) disable iff (rst)
        charge && !tick && charge_bits != '0 && EXT_W'(credit) > FLOOR
            |=> credit < $past(credit));

endmodule

// File: rtl/port_rate_policer.sv
module port_rate_policer
    import rl_pkg::*;
#(
    parameter int TICK_CYCLES     = 31250,
    parameter int STEP_CREDIT     = 8,
    parameter int MAX_FRAME_BYTES = 1916
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  logic              frm_egress,
    input  logic              frm_hi,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [RATE_W-1:0] cfg_wdata,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              pause_req
);
    localparam int CAP_MAX  = MAX_FRAME_BYTES * 8 + MAX_STEPS * STEP_CREDIT;
    localparam int MAG      = (CAP_MAX > FLOOR_MAG) ? CAP_MAX : FLOOR_MAG;
    localparam int CREDIT_W = $clog2(MAG + 1) + 1;

    frame_t   frm;
    verdict_t verdict;
    logic     tick;
    logic     fc_mode;
    logic [1:0] sel;
    logic       admit;

    logic [NUM_BKT-1:0][RATE_W-1:0] rate_new, rate_act;
    logic [NUM_BKT-1:0]             charge, unl, neg;
    logic signed [CREDIT_W-1:0]     credit [NUM_BKT];

    assign frm = '{valid: frm_valid, egress: frm_egress, hi: frm_hi, len: frm_len};
    assign sel = bucket_of(frm);

    rl_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rl_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rate_new  (rate_new),
        .rate_act  (rate_act),
        .fc_mode   (fc_mode)
    );

    for (genvar b = 0; b < NUM_BKT; b++) begin : g_bkt
        assign charge[b] = frm.valid && (sel == 2'(b)) && admit && !unl[b];
        assign neg[b]    = credit[b][CREDIT_W-1];

        rl_bucket #(
            .CREDIT_W        (CREDIT_W),
            .STEP_CREDIT     (STEP_CREDIT),
            .MAX_FRAME_BYTES (MAX_FRAME_BYTES)
        ) u_bucket (
            .clk         (clk),
            .rst         (rst),
            .tick        (tick),
            .rate_new    (rate_new[b]),
            .rate_act    (rate_act[b]),
            .charge      (charge[b]),
            .charge_bits (bits_of(frm.len)),
            .credit      (credit[b]),
            .unlimited   (unl[b])
        );
    end

    assign admit = unl[sel] || !neg[sel] || (!frm.egress && fc_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= '0;
        end else begin
            verdict.valid  <= frm.valid;
            verdict.accept <= frm.valid && admit;
        end
    end

    assign dec_valid  = verdict.valid;
    assign dec_accept = verdict.accept;
    assign pause_req  = fc_mode && ((!unl[REG_IN_LO] && neg[REG_IN_LO]) ||
                                    (!unl[REG_IN_HI] && neg[REG_IN_HI]));

    // R2: one verdict per event, none without
    a_r2_verdict_follows: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> dec_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !dec_valid);

    // R3: unlimited pair admits
    a_r3_unlimited_accept: assert property (@(posedge clk) disable iff (rst)
        frm_valid && unl[sel] |=> dec_accept);

    // R9: drop policy refuses on negative ingress credit
    a_r9_drop_negative: assert property (@(posedge clk) disable iff (rst)
        frm_valid && !frm_egress && !fc_mode && !unl[sel] && neg[sel] |=> !dec_accept);

    // R11: egress refuses on negative credit regardless of policy
    a_r11_egress_drop: assert property (@(posedge clk) disable iff (rst)
        frm_valid && frm_egress && !unl[sel] && neg[sel] |=> !dec_accept);

    // R10: pause is only raised in flow-control policy
    a_r10_pause_needs_fc: assert property (@(posedge clk) disable iff (rst)
        pause_req |-> fc_mode);

endmodule

// File: tb/test_port_rate_policer.sv
`timescale 1ns/1ps
module test_port_rate_policer;

    localparam int TICK  = 200;
    localparam int STEP  = 8;
    localparam int MAXB  = 1916;
    localparam int FLOOR = 2047 * 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_valid = 1'b0, frm_egress = 1'b0, frm_hi = 1'b0;
    logic [10:0] frm_len = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic        dec_valid, dec_accept, pause_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    port_rate_policer #(
        .TICK_CYCLES     (TICK),
        .STEP_CREDIT     (STEP),
        .MAX_FRAME_BYTES (MAXB)
    ) i_port_rate_policer (
        .clk        (clk),
        .rst        (rst),
        .frm_valid  (frm_valid),
        .frm_egress (frm_egress),
        .frm_hi     (frm_hi),
        .frm_len    (frm_len),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .pause_req  (pause_req)
    );

    // ---------------- reference model built from the requirements --------
    int    cred [4];
    int    ract [4];
    int    rsh  [4];
    bit    fc;
    int    bcnt;
    bit    exp_pause;
    bit    q_acc [$];
    string q_tag [$];
    string cur_tag = "";

    int  m_sel, m_base, m_sum, m_cap;
    bit  m_tick, m_adm;

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 4; b++) begin
                cred[b] = 0; ract[b] = 0; rsh[b] = 0;
            end
            fc = 1'b0; bcnt = 0; exp_pause = 1'b0;
        end else begin
            m_tick = (bcnt == TICK - 1);
            bcnt   = m_tick ? 0 : bcnt + 1;
            m_sel  = frm_egress * 2 + frm_hi;
            m_adm  = 1'b0;
            if (frm_valid) begin
                m_adm = (ract[m_sel] == 0) || (cred[m_sel] >= 0) || (!frm_egress && fc);
                q_acc.push_back(m_adm);
                q_tag.push_back(cur_tag);
            end
            for (int b = 0; b < 4; b++) begin
                m_base = cred[b];
                if (m_tick) begin
                    m_sum  = cred[b] + rsh[b] * STEP;
                    m_cap  = MAXB * 8 + rsh[b] * STEP;
                    m_base = (m_sum > m_cap) ? m_cap : m_sum;
                end
                if (frm_valid && m_sel == b && m_adm && ract[b] != 0)
                    m_base = m_base - int'(frm_len) * 8;
                if (m_base < -FLOOR) m_base = -FLOOR;
                cred[b] = m_base;
            end
            if (m_tick)
                for (int b = 0; b < 4; b++) ract[b] = rsh[b];
            if (cfg_we) begin
                if (cfg_addr < 3'd4)
                    rsh[cfg_addr] = (int'(cfg_wdata) > 3125) ? 3125 : int'(cfg_wdata);
                else if (cfg_addr == 3'd4)
                    fc = cfg_wdata[0];
            end
            exp_pause = fc && ((ract[0] != 0 && cred[0] < 0) ||
                               (ract[1] != 0 && cred[1] < 0));
        end
    end

    // ---------------- monitor -----------------------------------------------
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_checks++;
            if (pause_req !== exp_pause) begin
                n_fail++;
                $display("FAIL R10 pause_req actual=%0b expected=%0b at %0t",
                         pause_req, exp_pause, $time);
            end
            if (dec_valid === 1'b1) begin
                n_checks++;
                if (q_acc.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2 spurious verdict actual=1 expected=0 at %0t", $time);
                end else begin
                    bit    e;
                    string t;
                    e = q_acc.pop_front();
                    t = q_tag.pop_front();
                    if (dec_accept !== e) begin
                        n_fail++;
                        $display("FAIL %s dec_accept actual=%0b expected=%0b at %0t",
                                 t, dec_accept, e, $time);
                    end
                end
            end
        end
    end

    // ---------------- driver tasks ------------------------------------------
    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic send(input bit eg, input bit hi, input int len, input string tag);
        cur_tag    = tag;
        frm_valid  = 1'b1;
        frm_egress = eg;
        frm_hi     = hi;
        frm_len    = 11'(len);
        @(negedge clk);
        frm_valid  = 1'b0;
    endtask

    task automatic cfg_write(input int addr, input int data);
        cfg_we    = 1'b1;
        cfg_addr  = 3'(addr);
        cfg_wdata = 12'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // the next posedge will be a tick edge
    task automatic wait_tick_next();
        while (bcnt != TICK - 1) @(negedge clk);
    endtask

    task automatic pass_tick();
        wait_tick_next();
        @(negedge clk);
    endtask

    // ---------------- stimulus ----------------------------------------------
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        check_bit("R1 dec_valid after reset", dec_valid, 1'b0);
        check_bit("R1 pause_req after reset", pause_req, 1'b0);

        // R2: verdict one cycle after the event and only then
        send(1'b0, 1'b0, 64, "R2");
        check_bit("R2 dec_valid next cycle", dec_valid, 1'b1);
        @(negedge clk);
        check_bit("R2 dec_valid gone", dec_valid, 1'b0);

        // R1 R3: every pair unlimited after reset
        for (int b = 0; b < 4; b++) begin
            send(b[1], b[0], 1916, "R3");
            send(b[1], b[0], 2047, "R3");
        end
        idle(2);

        // R6 R8: staged rate on ingress low (10 steps = 80 bits per tick)
        cfg_write(0, 10);
        send(1'b0, 1'b0, 1500, "R6");
        send(1'b0, 1'b0, 1500, "R6");
        pass_tick();
        send(1'b0, 1'b0, 100, "R4");
        send(1'b0, 1'b0, 100, "R9");
        send(1'b0, 1'b1, 1916, "R8");
        send(1'b1, 1'b0, 1916, "R8");

        // R5 R7: clamped rate on ingress high, bucket fills to its cap
        cfg_write(1, 4000);
        pass_tick(); pass_tick(); pass_tick();
        for (int k = 0; k < 5; k++) send(1'b0, 1'b1, 1916, "R5 R7");

        // R11: egress high limited, flow control on, egress still drops
        cfg_write(3, 5);
        pass_tick();
        cfg_write(4, 1);
        send(1'b1, 1'b1, 1000, "R11");
        send(1'b1, 1'b1, 1000, "R11");
        send(1'b1, 1'b1, 10, "R11");
        idle(3);

        // R10: flow control admits and floors ingress low
        for (int k = 0; k < 25; k++) send(1'b0, 1'b0, 2047, "R10");
        idle(2);
        cfg_write(0, 3125);
        pass_tick();
        idle(2);
        send(1'b0, 1'b0, 1916, "R10");
        idle(2);
        cfg_write(4, 0);
        send(1'b0, 1'b0, 100, "R9");

        // R12: frames right before, on and right after the tick edge
        idle(1);
        while (bcnt != TICK - 2) @(negedge clk);
        send(1'b0, 1'b0, 100, "R12");
        send(1'b0, 1'b0, 100, "R12");
        send(1'b0, 1'b0, 100, "R12");
        wait_tick_next();
        send(1'b0, 1'b1, 1916, "R12");
        send(1'b0, 1'b1, 1916, "R12");
        wait_tick_next();
        cfg_write(2, 7);
        send(1'b1, 1'b0, 500, "R12");

        // R6: rate to zero only becomes unlimited at the tick
        send(1'b0, 1'b0, 1916, "R4");
        send(1'b0, 1'b0, 1916, "R4");
        send(1'b0, 1'b0, 1916, "R4");
        cfg_write(0, 0);
        send(1'b0, 1'b0, 1916, "R6");
        pass_tick();
        send(1'b0, 1'b0, 1916, "R6");
        send(1'b0, 1'b0, 1916, "R6");

        idle(4);
        check_bit("R2 all verdicts seen", q_acc.size() == 0, 1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule